// File: doc/BRIEF.md
# Data address compare debug unit

This block watches the load and store accesses of a processor pipeline and raises debug events when an access address meets a programmed condition. It has two compare value registers. They can act as two independent exact comparators. They can also be paired, either as a value and a bit mask or as the two ends of an inclusive address range. Each comparator can be limited to loads, stores or both. It can also be limited to user or supervisor accesses, and to one data address space.

A matching access is never blocked. Hits are collected over the life of an instruction and recorded only when the instruction terminates. A normal completion gives a precise report, which resumes after the access. A data storage fault gives an imprecise report: the faulting load/store address is the one to save, and an imprecise status bit is set. Hits are dropped on the second part of a split misaligned access, and for a load/store-multiple instruction interrupted before it completes. Status bits are recorded whatever the global debug enable says. Only the event signal to the interrupt logic depends on it.

Top module: `daddr_watch`

## Requirements
- R1: Writes with `wrEn` high load a register chosen by `wrSel`: 0 = compare value A, 1 = compare value B, 2 = control, 3 = status clear. Reset clears all registers, so `status` reads 0, no event fires and no comparator is armed.
- R2: Control bits [5:4] pick the match mode. In mode 00 or 11, comparator 0 hits when the address equals A and comparator 1 hits when it equals B.
- R3: In mode 01, comparator 0 hits when the address equals A in every bit where B is 1, and comparator 1 never hits.
- R4: In mode 10, comparator 0 hits when A <= address <= B (unsigned, both ends included), and comparator 1 never hits.
- R5: For comparator n, control bit 2n enables loads and bit 2n+1 enables stores. `accStore` = 1 marks a store.
- R6: For comparator n, control bit 7+2n set means only accesses whose `accUser` equals bit 6+2n can hit. Control bit 11+2n set means only accesses whose `accSpace` equals bit 10+2n can hit.
- R7: Status bits are recorded whether `dbgEnable` is high or low. `evtFire` pulses only if `dbgEnable` is high in the terminating cycle.
- R8: Hits are held until the instruction terminates. This includes hits from an access in the terminating cycle itself. On `instrDone`, the next edge sets the status bits: [0] comp 0 load, [1] comp 0 store, [2] comp 1 load, [3] comp 1 store. `evtFire` then pulses for one cycle with `evtImprecise` low.
- R9: When the instruction ends with `dsFault` and has hits, status bit [4] is set as well, and `saveLsAddr` pulses for one cycle. If `dbgEnable` is high, `evtFire` and `evtImprecise` pulse together.
- R10: An access with `accSecondHalf` high never hits.
- R11: `multiIntr` discards all held hits. Nothing is recorded and no event fires, and `multiIntr` takes priority over `instrDone` and `dsFault` in the same cycle.
- R12: Status bits stay set until a write with `wrSel` = 3 clears the bits that are 1 in `wrData[4:0]`. A new hit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select |
| wrData | input | ADDR_W | Write data |
| accValid | input | 1 | Data access present this cycle |
| accAddr | input | ADDR_W | Effective address of the access |
| accStore | input | 1 | 1 = store, 0 = load |
| accUser | input | 1 | 1 = user mode, 0 = supervisor |
| accSpace | input | 1 | Data address space bit |
| accSecondHalf | input | 1 | Access is the second part of a split misaligned access |
| instrDone | input | 1 | Current load/store instruction completes |
| dsFault | input | 1 | Current load/store instruction ends with a data storage fault |
| multiIntr | input | 1 | Load/store-multiple interrupted before completion |
| dbgEnable | input | 1 | Global debug exception enable |
| status | output | 5 | Sticky event status |
| evtFire | output | 1 | Debug event pulse toward the interrupt logic |
| evtImprecise | output | 1 | Fired event is imprecise |
| saveLsAddr | output | 1 | Save the load/store address rather than the next instruction's |

## Verification
The hardest situation to reach is a set of hits held across cycles of a single instruction and then thrown away. The bench creates it with an access that hits, followed one cycle later by `multiIntr`, and then a completion with no access at all. If stale hits leaked, they would show up in `status`. Accumulation over two accesses in different cycles is driven the same way, and `status` is checked before completion to confirm that nothing is recorded early.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
  localparam int NUM_CMP       = 2;
  localparam int HIT_W         = 2 * NUM_CMP;
  localparam int STAT_W        = HIT_W + 1;
  localparam int IMPRECISE_BIT = HIT_W;
  localparam int CTRL_W        = 14;
  localparam int MODE_LSB      = 4;
  localparam int PRIV_LSB      = 6;
  localparam int SPACE_LSB     = 10;

  typedef enum logic [1:0] {
    SEL_CMP_A = 2'd0,
    SEL_CMP_B = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_CLEAR = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    MODE_EXACT     = 2'd0,
    MODE_MASKED    = 2'd1,
    MODE_RANGE     = 2'd2,
    MODE_EXACT_ALT = 2'd3
  } match_mode_e;

  typedef struct packed {
    logic ldCmpA;
    logic ldCmpB;
    logic ldCtrl;
    logic clrStatus;
    logic accumulate;
    logic commit;
    logic discard;
    logic markImprecise;
  } dp_strobe_t;
endpackage

// File: rtl/dacu_datapath.sv
module dacu_datapath
  import dacu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strb,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  logic              accUser,
  input  logic              accSpace,
  input  logic              accSecondHalf,
  output logic [STAT_W-1:0] status,
  output logic              anyHit
);
  logic [ADDR_W-1:0] cmpA;
  logic [ADDR_W-1:0] cmpB;
  logic [CTRL_W-1:0] ctrl;
  logic [HIT_W-1:0]  hitNow;
  logic [HIT_W-1:0]  pending;
  logic [HIT_W-1:0]  hitAll;
  logic [STAT_W-1:0] setBits;
  logic [STAT_W-1:0] clrBits;
  match_mode_e       mode;

  assign mode = match_mode_e'(ctrl[MODE_LSB +: 2]);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpA <= '0;
      cmpB <= '0;
      ctrl <= '0;
    end else begin
      if (strb.ldCmpA) cmpA <= wrData;
      if (strb.ldCmpB) cmpB <= wrData;
      if (strb.ldCtrl) ctrl <= wrData[CTRL_W-1:0];
    end
  end

  // one comparator slice per compare register
  for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
    localparam bit IS_PRIMARY = (gi == 0);
    logic [ADDR_W-1:0] ownVal;
    logic [1:0]        typeEn;
    logic [1:0]        privSel;
    logic [1:0]        spaceSel;
    logic              addrMatch;
    logic              qualOk;
    logic              eligible;

    assign ownVal   = IS_PRIMARY ? cmpA : cmpB;
    assign typeEn   = ctrl[2*gi +: 2];
    assign privSel  = ctrl[PRIV_LSB + 2*gi +: 2];
    assign spaceSel = ctrl[SPACE_LSB + 2*gi +: 2];

    always_comb begin
      case (mode)
        MODE_MASKED: addrMatch = IS_PRIMARY && (((accAddr ^ cmpA) & cmpB) == '0);
        MODE_RANGE:  addrMatch = IS_PRIMARY && (accAddr >= cmpA) && (accAddr <= cmpB);
        default:     addrMatch = (accAddr == ownVal);
      endcase
    end

    assign qualOk   = (!privSel[1] || (privSel[0] == accUser)) &&
                      (!spaceSel[1] || (spaceSel[0] == accSpace));
    assign eligible = accValid && !accSecondHalf && addrMatch && qualOk;

    assign hitNow[2*gi]     = eligible && !accStore && typeEn[0];
    assign hitNow[2*gi + 1] = eligible &&  accStore && typeEn[1];
  end

  assign hitAll = pending | hitNow;
  assign anyHit = |hitAll;

  // hits held for the life of the instruction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           pending <= '0;
    else if (strb.commit || strb.discard) pending <= '0;
    else if (strb.accumulate)            pending <= hitAll;
  end

  // sticky status, set wins over clear
  always_comb begin
    setBits = '0;
    if (strb.commit) begin
      setBits[HIT_W-1:0]    = hitAll;
      setBits[IMPRECISE_BIT] = strb.markImprecise && anyHit;
    end
    clrBits = strb.clrStatus ? wrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrBits) | setBits;
  end
endmodule

// File: rtl/dacu_control.sv
module dacu_control
  import dacu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       instrDone,
  input  logic       dsFault,
  input  logic       multiIntr,
  input  logic       dbgEnable,
  input  logic       anyHit,
  output dp_strobe_t strb,
  output logic       evtFire,
  output logic       evtImprecise,
  output logic       saveLsAddr
);
  logic reportNow;

  always_comb begin
    strb               = '0;
    strb.ldCmpA        = wrEn && (wr_sel_e'(wrSel) == SEL_CMP_A);
    strb.ldCmpB        = wrEn && (wr_sel_e'(wrSel) == SEL_CMP_B);
    strb.ldCtrl        = wrEn && (wr_sel_e'(wrSel) == SEL_CTRL);
    strb.clrStatus     = wrEn && (wr_sel_e'(wrSel) == SEL_CLEAR);
    strb.discard       = multiIntr;
    strb.commit        = (instrDone || dsFault) && !multiIntr;
    strb.accumulate    = !(strb.commit || strb.discard);
    strb.markImprecise = strb.commit && dsFault;
  end

  assign reportNow = strb.commit && anyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFire      <= 1'b0;
      evtImprecise <= 1'b0;
      saveLsAddr   <= 1'b0;
    end else begin
      evtFire      <= reportNow && dbgEnable;
      evtImprecise <= reportNow && dbgEnable && dsFault;
      saveLsAddr   <= reportNow && dsFault;
    end
  end
endmodule

// File: rtl/daddr_watch.sv
module daddr_watch
  import dacu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  logic              accUser,
  input  logic              accSpace,
  input  logic              accSecondHalf,
  input  logic              instrDone,
  input  logic              dsFault,
  input  logic              multiIntr,
  input  logic              dbgEnable,
  output logic [4:0]        status,
  output logic              evtFire,
  output logic              evtImprecise,
  output logic              saveLsAddr
);
  dp_strobe_t strb;
  logic       anyHit;

  dacu_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .instrDone(instrDone), .dsFault(dsFault), .multiIntr(multiIntr),
    .dbgEnable(dbgEnable), .anyHit(anyHit), .strb(strb),
    .evtFire(evtFire), .evtImprecise(evtImprecise), .saveLsAddr(saveLsAddr)
  );

  dacu_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .accValid(accValid), .accAddr(accAddr), .accStore(accStore),
    .accUser(accUser), .accSpace(accSpace), .accSecondHalf(accSecondHalf),
    .status(status), .anyHit(anyHit)
  );
endmodule

// File: rtl/daddr_watch_chk.sv
module daddr_watch_chk
  import dacu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [STAT_W-1:0] wrClrBits,
  input logic              instrDone,
  input logic              dsFault,
  input logic              multiIntr,
  input logic              dbgEnable,
  input logic [STAT_W-1:0] status,
  input logic              evtFire,
  input logic              evtImprecise,
  input logic              saveLsAddr
);
  logic [STAT_W-1:0] clrLast;
  logic              endedLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrLast   <= '0;
      endedLast <= 1'b0;
    end else begin
      clrLast   <= (wrEn && wrSel == 2'd3) ? wrClrBits : '0;
      endedLast <= (instrDone || dsFault) && !multiIntr;
    end
  end

  AST_FIRE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    evtFire |-> $past(dbgEnable)); // R7
  AST_FIRE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    evtFire |-> endedLast); // R8
  AST_STATUS_SET_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~$past(status)) != '0) |-> endedLast); // R8
  AST_IMPRECISE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    evtImprecise |-> (evtFire && $past(dsFault) && status[IMPRECISE_BIT])); // R9
  AST_SAVE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    saveLsAddr |-> ($past(dsFault) && status[IMPRECISE_BIT])); // R9
  AST_MULTI_DISCARDS: assert property (@(posedge clk) disable iff (!rstN)
    $past(multiIntr) |-> (!evtFire && !saveLsAddr)); // R11
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(status) & ~clrLast & ~status) == '0)); // R12
endmodule

bind daddr_watch daddr_watch_chk chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
  .wrClrBits(wrData[dacu_pkg::STAT_W-1:0]),
  .instrDone(instrDone), .dsFault(dsFault), .multiIntr(multiIntr),
  .dbgEnable(dbgEnable), .status(status), .evtFire(evtFire),
  .evtImprecise(evtImprecise), .saveLsAddr(saveLsAddr)
);

// File: tb/daddr_watch_test.sv
module daddr_watch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accStore = 1'b0, accUser = 1'b0, accSpace = 1'b0, accSecondHalf = 1'b0;
  logic        instrDone = 1'b0, dsFault = 1'b0, multiIntr = 1'b0, dbgEnable = 1'b1;
  logic [4:0]  status;
  logic        evtFire, evtImprecise, saveLsAddr;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  daddr_watch uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .accValid(accValid), .accAddr(accAddr), .accStore(accStore),
    .accUser(accUser), .accSpace(accSpace), .accSecondHalf(accSecondHalf),
    .instrDone(instrDone), .dsFault(dsFault), .multiIntr(multiIntr),
    .dbgEnable(dbgEnable), .status(status), .evtFire(evtFire),
    .evtImprecise(evtImprecise), .saveLsAddr(saveLsAddr)
  );

  // term: 0 = completes, 1 = data storage fault, 2 = interrupted multiple
  typedef struct packed {
    logic [13:0] ctrl;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] addr;
    logic        store;
    logic        user;
    logic        space;
    logic        second;
    logic [1:0]  term;
    logic        dbg;
    logic [4:0]  expStat;
    logic        expFire;
    logic        expImp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{14'h000F, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h01, 1'b1, 1'b0, 4'd2},  // R2
    '{14'h000F, 32'h1000, 32'h2000, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h08, 1'b1, 1'b0, 4'd2},  // R2
    '{14'h000F, 32'h1000, 32'h2000, 32'h1004, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd2},  // R2
    '{14'h001F, 32'h1000, 32'hFFFFFF00, 32'h10A4, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h02, 1'b1, 1'b0, 4'd3}, // R3
    '{14'h001F, 32'h1000, 32'hFFFFFF00, 32'h11A4, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd3}, // R3
    '{14'h001F, 32'h1000, 32'hFFFFFF00, 32'hFFFFFF00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd3}, // R3
    '{14'h002F, 32'h1000, 32'h1FFF, 32'h1FFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h01, 1'b1, 1'b0, 4'd4},  // R4
    '{14'h002F, 32'h1000, 32'h1FFF, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd4},  // R4
    '{14'h002F, 32'h1000, 32'h1FFF, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h02, 1'b1, 1'b0, 4'd4},  // R4
    '{14'h002F, 32'h1000, 32'h1FFF, 32'h0FFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd4},  // R4
    '{14'h0001, 32'h1000, 32'h2000, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd5},  // R5
    '{14'h0002, 32'h1000, 32'h2000, 32'h1000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h02, 1'b1, 1'b0, 4'd5},  // R5
    '{14'h00C3, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd6},  // R6
    '{14'h00C3, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 5'h01, 1'b1, 1'b0, 4'd6},  // R6
    '{14'h0803, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd6},  // R6
    '{14'h0803, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'h01, 1'b1, 1'b0, 4'd6},  // R6
    '{14'h000F, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 5'h01, 1'b0, 1'b0, 4'd7},  // R7
    '{14'h000F, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 5'h11, 1'b1, 1'b1, 4'd9},  // R9
    '{14'h000F, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 5'h00, 1'b0, 1'b0, 4'd11}, // R11
    '{14'h000F, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 5'h00, 1'b0, 1'b0, 4'd10}, // R10
    '{14'h000F, 32'h1000, 32'h2000, 32'h1004, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 5'h00, 1'b0, 1'b0, 4'd9},  // R9
    '{14'h000F, 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 5'h11, 1'b0, 1'b0, 4'd9}   // R9
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] sel, input logic [31:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic access(input logic [31:0] addr, input logic st);
    accValid = 1'b1; accAddr = addr; accStore = st;
  endtask

  task automatic idle();
    accValid = 1'b0; accStore = 1'b0; accUser = 1'b0; accSpace = 1'b0; accSecondHalf = 1'b0;
    instrDone = 1'b0; dsFault = 1'b0; multiIntr = 1'b0;
  endtask

  task automatic setup(input logic [13:0] ctrl, input logic [31:0] a, input logic [31:0] b);
    doWrite(2'd0, a);
    doWrite(2'd1, b);
    doWrite(2'd2, {18'd0, ctrl});
    doWrite(2'd3, 32'h1F);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(1, "reset status", {27'd0, status}, 32'h0);
    chk(1, "reset evtFire", {31'd0, evtFire}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset leaves comparators unarmed
    access(32'h0, 1'b0); instrDone = 1'b1;
    @(negedge clk); idle();
    @(negedge clk);
    chk(1, "unarmed after reset", {27'd0, status}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].ctrl, VECS[i].a, VECS[i].b);
      dbgEnable = VECS[i].dbg;
      access(VECS[i].addr, VECS[i].store);
      accUser = VECS[i].user; accSpace = VECS[i].space; accSecondHalf = VECS[i].second;
      @(negedge clk);
      idle();
      case (VECS[i].term)
        2'd0:    instrDone = 1'b1;
        2'd1:    dsFault = 1'b1;
        default: multiIntr = 1'b1;
      endcase
      @(negedge clk);
      idle();
      chk(VECS[i].req, $sformatf("vec %0d status", i), {27'd0, status}, {27'd0, VECS[i].expStat});
      chk(VECS[i].req, $sformatf("vec %0d evtFire", i), {31'd0, evtFire}, {31'd0, VECS[i].expFire});
      chk(VECS[i].req, $sformatf("vec %0d evtImprecise", i), {31'd0, evtImprecise}, {31'd0, VECS[i].expImp});
      chk(VECS[i].req, $sformatf("vec %0d saveLsAddr", i), {31'd0, saveLsAddr},
          {31'd0, (VECS[i].expStat != 5'h0) && (VECS[i].term == 2'd1)});
    end
    dbgEnable = 1'b1;

    // R8: accumulation over two accesses, nothing recorded before completion
    setup(14'h000F, 32'h1000, 32'h2000);
    access(32'h1000, 1'b0);
    @(negedge clk); access(32'h2000, 1'b1);
    @(negedge clk); idle();
    chk(8, "no status before completion", {27'd0, status}, 32'h0);
    chk(8, "no fire before completion", {31'd0, evtFire}, 32'h0);
    instrDone = 1'b1;
    @(negedge clk); idle();
    chk(8, "accumulated status", {27'd0, status}, 32'h09);
    chk(8, "single fire", {31'd0, evtFire}, 32'h1);
    chk(8, "precise", {31'd0, evtImprecise}, 32'h0);
    @(negedge clk);
    chk(8, "fire is a pulse", {31'd0, evtFire}, 32'h0);
    chk(12, "sticky after idle", {27'd0, status}, 32'h09);

    // R12: write-1-to-clear of selected bits
    doWrite(2'd3, 32'h01);
    chk(12, "partial clear", {27'd0, status}, 32'h08);
    doWrite(2'd3, 32'h00);
    chk(12, "zero clear keeps", {27'd0, status}, 32'h08);

    // R12: hit in the clear cycle wins
    wrEn = 1'b1; wrSel = 2'd3; wrData = 32'h1F;
    access(32'h1000, 1'b0); instrDone = 1'b1;
    @(negedge clk); wrEn = 1'b0; idle();
    chk(12, "set wins over clear", {27'd0, status}, 32'h01);

    // R8: access in the completing cycle counts
    doWrite(2'd3, 32'h1F);
    access(32'h2000, 1'b0); instrDone = 1'b1;
    @(negedge clk); idle();
    chk(8, "same-cycle access", {27'd0, status}, 32'h04);

    // R11: held hit discarded by interrupted multiple
    doWrite(2'd3, 32'h1F);
    access(32'h1000, 1'b0);
    @(negedge clk); idle(); multiIntr = 1'b1;
    @(negedge clk); idle(); instrDone = 1'b1;
    @(negedge clk); idle();
    chk(11, "discarded hit status", {27'd0, status}, 32'h0);
    chk(11, "discarded hit fire", {31'd0, evtFire}, 32'h0);

    // R11: priority over completion in the same cycle
    access(32'h1000, 1'b0); instrDone = 1'b1; multiIntr = 1'b1;
    @(negedge clk); idle();
    chk(11, "multi beats done", {27'd0, status}, 32'h0);

    // R1: reset clears configuration
    rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access(32'h1000, 1'b0); instrDone = 1'b1;
    @(negedge clk); idle();
    chk(1, "config cleared by reset", {27'd0, status}, 32'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule